// File: doc/BRIEF.md
# Static RAM Strobe Sequencer

This block turns single-word read and write requests from on-chip logic into correctly timed strobe sequences for an external byte-wide static RAM with an 18-bit address. The memory has no clock. It has active-low chip-select, write-strobe and output-gate inputs and a shared data bus. The controller owns the address lines and the write-data drivers. It separates its own drivers from the memory's outputs with a dedicated driver-enable output, so the pad ring can build the tristate buffer.

A request is taken only while the sequencer is idle. The address and write data are captured at that moment, so the requester may change its inputs afterwards. Each phase lasts a number of clock cycles set by a parameter: access wait, turn-around, write-pulse width and data setup. The same logic therefore meets the memory's nanosecond limits at any clock period. The end of each access is marked by a one-cycle acknowledge. On a read, the captured byte is presented in that same cycle.

Top module: `sram_ctl`

## Requirements
- R1: While rst_ni is low, and after it is released with no request, mem_ce_n_o, mem_we_n_o and mem_oe_n_o are 1 and mem_dq_oe_o and ack_o are 0.
- R2: A request (req_i high at a clock edge) is taken only when the sequencer is idle. A request presented during an access is ignored: it causes no memory write and no extra acknowledge.
- R3: A read holds mem_ce_n_o=0, mem_oe_n_o=0, mem_we_n_o=1 for exactly READ_WAIT cycles after the accepting edge. It samples mem_dq_i at the last of those edges. ack_o rises READ_WAIT cycles after the accepting edge.
- R4: A write first holds mem_ce_n_o=0 with mem_we_n_o=1 and the drivers off for TURN_AROUND cycles. It then holds mem_we_n_o=0 with mem_dq_oe_o=1 for max(WE_PULSE, DATA_SETUP) cycles. It ends with one cycle of mem_we_n_o=1, mem_ce_n_o=0 and the drivers still on, during which ack_o is high.
- R5: mem_oe_n_o stays 1 for the whole write sequence. mem_dq_oe_o is never 1 while mem_oe_n_o is 0. The drivers only switch on one cycle or more after the output gate was high.
- R6: mem_addr_o and mem_dq_o carry the address and data captured at the accepting edge. They do not change while mem_ce_n_o stays low, even if addr_i and wdata_i change.
- R7: ack_o is high for exactly one cycle per access. On a read, rdata_o holds the sampled byte in that cycle.
- R8: In the cycle after ack_o, mem_ce_n_o is 1, so every two accesses are separated by at least one deselected cycle.
- R9: mem_ce_n_o=1 forces mem_we_n_o=1, mem_oe_n_o=1 and mem_dq_oe_o=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write byte |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Read byte, valid with ack_o |
| mem_addr_o | output | ADDR_W | Memory address lines |
| mem_dq_o | output | DATA_W | Data toward the memory |
| mem_dq_oe_o | output | 1 | Enable for the data drivers |
| mem_dq_i | input | DATA_W | Data from the memory bus |
| mem_ce_n_o | output | 1 | Chip select, active low |
| mem_we_n_o | output | 1 | Write strobe, active low |
| mem_oe_n_o | output | 1 | Output gate, active low |

## Verification
A wrong state or counter value shows at the strobe pins in the very next cycle. It can appear as a strobe pattern that does not match the phase, as a write pulse or access window of the wrong length, or as an acknowledge that arrives one or more cycles early or late. The memory model returns garbage until the programmed access time has elapsed, so a read that is sampled too early returns a wrong byte in its acknowledge cycle. Requests injected mid-access and changed request inputs expose latching or acceptance faults when the affected location is read back later.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACCESS,
    ST_RD_DONE,
    ST_WR_TURN,
    ST_WR_PULSE,
    ST_WR_END
  } ctl_state_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } strobe_t;

  localparam strobe_t STROBE_OFF = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

  function automatic strobe_t strobe_of(ctl_state_e s);
    strobe_t r;
    r = STROBE_OFF;
    case (s)
      ST_RD_ACCESS: r = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, dq_oe: 1'b0};
      ST_WR_TURN:   r = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
      ST_WR_PULSE:  r = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, dq_oe: 1'b1};
      ST_WR_END:    r = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b1};
      default:      r = STROBE_OFF;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
`timescale 1ns/1ps
module sram_ctl_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= load_val_i;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  // phase ends on the cycle the count reaches one
  assign last_o = (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/sram_ctl_fsm.sv
`timescale 1ns/1ps
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int unsigned READ_WAIT   = 2,
  parameter int unsigned WE_LOW      = 2,
  parameter int unsigned TURN_AROUND = 1,
  parameter int unsigned CNT_W       = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             last_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             ack_o,
  output strobe_t          strobe_o
);
  ctl_state_e state_q, state_d;
  strobe_t    strobe_q;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    accept_o   = 1'b0;
    capture_o  = 1'b0;
    case (state_q)
      ST_IDLE: if (req_i) begin
        accept_o = 1'b1;
        load_o   = 1'b1;
        if (we_i) begin
          state_d    = ST_WR_TURN;
          load_val_o = CNT_W'(TURN_AROUND);
        end else begin
          state_d    = ST_RD_ACCESS;
          load_val_o = CNT_W'(READ_WAIT);
        end
      end
      ST_RD_ACCESS: if (last_i) begin
        capture_o = 1'b1;
        state_d   = ST_RD_DONE;
      end
      ST_RD_DONE: state_d = ST_IDLE;
      ST_WR_TURN: if (last_i) begin
        load_o     = 1'b1;
        load_val_o = CNT_W'(WE_LOW);
        state_d    = ST_WR_PULSE;
      end
      ST_WR_PULSE: if (last_i) state_d = ST_WR_END;
      ST_WR_END:   state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  // strobes registered from next state: glitch-free pins, aligned with state_q
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      strobe_q <= STROBE_OFF;
    end else begin
      state_q  <= state_d;
      strobe_q <= strobe_of(state_d);
    end
  end

  assign ack_o    = (state_q == ST_RD_DONE) || (state_q == ST_WR_END);
  assign strobe_o = strobe_q;
endmodule

// File: rtl/sram_ctl_dpath.sv
`timescale 1ns/1ps
module sram_ctl_dpath #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
      rdata_o <= '0;
    end else begin
      if (accept_i) begin
        addr_o  <= addr_i;
        wdata_o <= wdata_i;
      end
      if (capture_i) rdata_o <= mem_dq_i;
    end
  end
endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 18,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned READ_WAIT   = 2,
  parameter int unsigned WE_PULSE    = 2,
  parameter int unsigned DATA_SETUP  = 1,
  parameter int unsigned TURN_AROUND = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_ce_n_o,
  output logic              mem_we_n_o,
  output logic              mem_oe_n_o
);
  // data drive covers the setup window, so the low time is the larger of the two
  localparam int unsigned WE_LOW   = (WE_PULSE > DATA_SETUP) ? WE_PULSE : DATA_SETUP;
  localparam int unsigned MAX_A    = (READ_WAIT > WE_LOW) ? READ_WAIT : WE_LOW;
  localparam int unsigned MAX_WAIT = (MAX_A > TURN_AROUND) ? MAX_A : TURN_AROUND;
  localparam int unsigned CNT_W    = $clog2(MAX_WAIT + 1);

  logic             load, last, accept, capture;
  logic [CNT_W-1:0] load_val;
  strobe_t          strobe;

  sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni,
    .load_i     (load),
    .load_val_i (load_val),
    .last_o     (last)
  );

  sram_ctl_fsm #(
    .READ_WAIT(READ_WAIT), .WE_LOW(WE_LOW), .TURN_AROUND(TURN_AROUND), .CNT_W(CNT_W)
  ) u_fsm (
    .clk_i, .rst_ni,
    .req_i, .we_i,
    .last_i     (last),
    .load_o     (load),
    .load_val_o (load_val),
    .accept_o   (accept),
    .capture_o  (capture),
    .ack_o,
    .strobe_o   (strobe)
  );

  sram_ctl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk_i, .rst_ni,
    .accept_i  (accept),
    .capture_i (capture),
    .addr_i, .wdata_i, .mem_dq_i,
    .addr_o    (mem_addr_o),
    .wdata_o   (mem_dq_o),
    .rdata_o
  );

  assign mem_ce_n_o  = strobe.ce_n;
  assign mem_we_n_o  = strobe.we_n;
  assign mem_oe_n_o  = strobe.oe_n;
  assign mem_dq_oe_o = strobe.dq_oe;
endmodule

// File: rtl/sram_ctl_chk.sv
`timescale 1ns/1ps
module sram_ctl_chk #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WE_LOW = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ack_o,
  input logic              mem_ce_n_o,
  input logic              mem_we_n_o,
  input logic              mem_oe_n_o,
  input logic              mem_dq_oe_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_dq_o
);
  logic [15:0] we_low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          we_low_cnt <= '0;
    else if (!mem_we_n_o) we_low_cnt <= (we_low_cnt == 16'hffff) ? we_low_cnt : we_low_cnt + 1'b1;
    else                  we_low_cnt <= '0;
  end

  AST_DESELECT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ce_n_o |-> (mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o)); // R9
  AST_READ_PATTERN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_n_o |-> (!mem_ce_n_o && mem_we_n_o)); // R3
  AST_NO_CONTENTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_n_o); // R5
  AST_DRIVE_AFTER_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> ($past(mem_oe_n_o) && !$past(mem_ce_n_o))); // R5
  AST_WE_MIN_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> (we_low_cnt >= 16'(WE_LOW))); // R4
  AST_WE_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> mem_dq_oe_o); // R4
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_n_o && !$past(mem_ce_n_o)) |-> $stable(mem_addr_o)); // R6
  AST_WDATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_dq_oe_o && $past(mem_dq_oe_o)) |-> $stable(mem_dq_o)); // R6
  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o); // R7
  AST_GAP_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> mem_ce_n_o); // R8
endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WE_LOW(WE_LOW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ack_o       (ack_o),
  .mem_ce_n_o  (mem_ce_n_o),
  .mem_we_n_o  (mem_we_n_o),
  .mem_oe_n_o  (mem_oe_n_o),
  .mem_dq_oe_o (mem_dq_oe_o),
  .mem_addr_o  (mem_addr_o),
  .mem_dq_o    (mem_dq_o)
);

// File: tb/sram_ctl_test.sv
`timescale 1ns/1ps
module sram_ctl_test;
  localparam int AW = 18, DW = 8;
  localparam int RW = 2, WP = 2, DS = 1, TA = 1;
  localparam int WL = (WP > DS) ? WP : DS;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic ack_o, mem_dq_oe_o, mem_ce_n_o, mem_we_n_o, mem_oe_n_o;
  logic [DW-1:0] rdata_o, mem_dq_o;
  logic [DW-1:0] mem_dq_i = 8'hEE;
  logic [AW-1:0] mem_addr_o;

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;
  int rd_age = 0;
  logic [DW-1:0] model_mem [int];
  logic [DW-1:0] ref_mem [int];

  always #2 clk = ~clk; // 250 MHz

  sram_ctl #(.READ_WAIT(RW), .WE_PULSE(WP), .DATA_SETUP(DS), .TURN_AROUND(TA)) uut (
    .clk_i(clk), .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .ack_o, .rdata_o,
    .mem_addr_o, .mem_dq_o, .mem_dq_oe_o, .mem_dq_i, .mem_ce_n_o, .mem_we_n_o, .mem_oe_n_o
  );

  function automatic logic [DW-1:0] bg(logic [AW-1:0] a);
    return a[7:0] ^ a[17:10] ^ 8'h5A;
  endfunction

  // memory model: writes while selected and strobed, read data valid only after RW-1 edges
  always @(posedge clk) begin
    if (rst_ni && !mem_ce_n_o && !mem_we_n_o && mem_dq_oe_o) model_mem[int'(mem_addr_o)] = mem_dq_o;
    if (rst_ni && !mem_ce_n_o && !mem_oe_n_o && mem_we_n_o) rd_age <= rd_age + 1;
    else rd_age <= 0;
  end
  always @(negedge clk) begin
    if (!mem_ce_n_o && !mem_oe_n_o && mem_we_n_o && rd_age >= RW - 1)
      mem_dq_i <= model_mem.exists(int'(mem_addr_o)) ? model_mem[int'(mem_addr_o)] : bg(mem_addr_o);
    else
      mem_dq_i <= 8'hEE;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] exp_rd(logic [AW-1:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : bg(a);
  endfunction

  // one access; poke injects a write request in the first busy cycle (R2)
  task automatic access(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit poke);
    int lat, got;
    logic [3:0] pat, epat;
    lat = w ? (TA + WL + 1) : (RW + 1);
    got = 0;
    @(negedge clk);
    chk(mem_ce_n_o === 1'b1, "R8 idle before request", 32'(mem_ce_n_o), 32'd1);
    req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d;
    @(posedge clk);
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      if (n == 1) begin
        req_i = poke; we_i = 1'b1;
        addr_i = ~a; wdata_i = ~d; // R6 inputs change after capture
      end else req_i = 1'b0;
      pat = {mem_ce_n_o, mem_we_n_o, mem_oe_n_o, mem_dq_oe_o};
      if (n < lat) begin
        if (!w) epat = 4'b0100;
        else if (n <= TA) epat = 4'b0110;
        else epat = 4'b0011;
        chk(pat === epat, w ? "R4/R5 write strobes" : "R3 read strobes", 32'(pat), 32'(epat));
        chk(mem_addr_o === a, "R6 address held", 32'(mem_addr_o), 32'(a));
        if (w && n > TA) chk(mem_dq_o === d, "R6 write data held", 32'(mem_dq_o), 32'(d));
      end
      if (ack_o === 1'b1) begin got = n; break; end
    end
    chk(got == lat, "R3/R4 ack latency", 32'(got), 32'(lat));
    if (w) begin
      pat = {mem_ce_n_o, mem_we_n_o, mem_oe_n_o, mem_dq_oe_o};
      chk(pat === 4'b0111, "R4 write end cycle", 32'(pat), 32'h7);
      ref_mem[int'(a)] = d;
    end else
      chk(rdata_o === exp_rd(a), "R7 read data with ack", 32'(rdata_o), 32'(exp_rd(a)));
    @(negedge clk);
    chk(ack_o === 1'b0, "R7 ack single cycle", 32'(ack_o), 32'd0);
    chk(mem_ce_n_o === 1'b1, "R8 deselect after ack", 32'(mem_ce_n_o), 32'd1);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk({mem_ce_n_o, mem_we_n_o, mem_oe_n_o, mem_dq_oe_o, ack_o} === 5'b11100, "R1 in reset",
        32'({mem_ce_n_o, mem_we_n_o, mem_oe_n_o, mem_dq_oe_o, ack_o}), 32'h1c);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk({mem_ce_n_o, mem_we_n_o, mem_oe_n_o, mem_dq_oe_o, ack_o} === 5'b11100, "R1 after release",
        32'({mem_ce_n_o, mem_we_n_o, mem_oe_n_o, mem_dq_oe_o, ack_o}), 32'h1c);
    // directed corners
    access(1'b0, 18'h00000, 8'h00, 1'b0);
    access(1'b1, 18'h00000, 8'hA5, 1'b0);
    access(1'b1, 18'h3FFFF, 8'h3C, 1'b0);
    access(1'b0, 18'h3FFFF, 8'h00, 1'b0);
    access(1'b0, 18'h00000, 8'h00, 1'b0);
    access(1'b1, 18'h12345, 8'hFF, 1'b0);
    // R2: write request poked during a read must not reach the memory
    access(1'b0, 18'h00055, 8'h00, 1'b1);
    access(1'b0, 18'h3FFAA, 8'h00, 1'b0);
    chk(rdata_o === exp_rd(18'h3FFAA), "R2 poked address untouched", 32'(rdata_o), 32'(exp_rd(18'h3FFAA)));
    access(1'b1, 18'h00010, 8'h77, 1'b1);
    access(1'b0, 18'h3FFEF, 8'h00, 1'b0);
    // random mix over a small pool at both ends of the address space
    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] a;
      a = 18'($urandom % 24);
      if ($urandom % 2) a = ~a;
      access(1'($urandom % 2), a, 8'($urandom), 1'b0);
    end
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    while (cycles < 150000) begin @(posedge clk); cycles++; end
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule